// File: doc/BRIEF.md
# Shared-Register Event Counter Unit

This block is a small performance monitor. It holds three 32-bit counters: one that counts clock cycles and two that count pulses from a wide vector of event inputs. Each event counter picks its source with an 8-bit selector code. The selector code indexes the event vector.

One control word gathers all of the configuration and status: the run enable, the counter clear strobes, the interrupt enables, the sticky overflow flags and both selectors. Software clears an overflow flag by writing a one to its position. A simple single-cycle register bus reads and writes the control word and each counter. A single interrupt output is raised when an enabled flag is set.

Top module: `evt_mon_unit`

## Requirements
- R1: While control bit 0 (run enable) is 0, no counter changes except by a bus write or a clear strobe. While it is 1, the cycle counter adds one on every clock edge.
- R2: A control write with bit 1 set clears both event counters, and a control write with bit 2 set clears the cycle counter. Neither bit is stored, and both read back as 0.
- R3: When a counter wraps from all ones to 0, its overflow flag is set on the same clock edge. The flags sit at bit 8 (event counter 0), bit 9 (event counter 1) and bit 10 (cycle counter).
- R4: Writing 1 to a flag position clears that flag, and writing 0 leaves it unchanged. When a wrap and a clearing write land on the same edge, the flag ends up set.
- R5: The interrupt output equals the OR over all counters of (flag AND enable), delayed by one register stage. The enables sit at bit 4 (event counter 0), bit 5 (event counter 1) and bit 6 (cycle counter).
- R6: Event counter 0 uses the selector in bits 19:12, and event counter 1 uses the selector in bits 27:20. While enabled, an event counter adds one on each edge where the input indexed by its selector is high. Selector code 0xFF never counts.
- R7: Bits 31:28, bit 7, bit 11 and bit 3 of the control word cannot be written and read as 0.
- R8: A bus write to a counter wins over an increment on the same edge.
- R9: Bus address 0 is the control word, 1 is event counter 0, 2 is event counter 1 and 3 is the cycle counter. Reads are combinational and return the state written. After reset, every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | 2 | Register select: 0 control, 1 event 0, 2 event 1, 3 cycles |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data of the addressed register |
| evt_i | input | 256 | Event pulse inputs, indexed by selector code |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A bus write lands on the next clock edge and is readable right after it. A counter first advances on the edge after the one that stored the enable. A wrap and its flag appear on the same edge, and the interrupt follows one edge later. The bench drives inputs and samples outputs on falling edges, so every stimulus is tied to a known rising edge. It counts those edges exactly (enable edge, event edges, disabling edge) to form each expected value. It then reads the outputs before the next rising edge.

// File: rtl/evt_mon_pkg.sv
`timescale 1ns/1ps
package evt_mon_pkg;
   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 2;
   localparam int NUM_CNT  = 3;
   // counter index order matches enable / flag bit order
   localparam int CNT_E0   = 0;
   localparam int CNT_E1   = 1;
   localparam int CNT_CY   = 2;
   // control word layout
   localparam int EN_BIT   = 0;
   localparam int EVCLR_BIT = 1;
   localparam int CYCLR_BIT = 2;
   localparam int IEN_LSB  = 4;
   localparam int FLAG_LSB = 8;
   localparam int SEL0_LSB = 12;
   localparam int SEL1_LSB = 20;
   localparam int SEL_TOP  = 28;
endpackage

// File: rtl/evt_mon_ctr.sv
`timescale 1ns/1ps
module evt_mon_ctr #(
   parameter int W = 32
)(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   input  logic         clr_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   if (W < 2) begin : g_bad_w
      $error("evt_mon_ctr: W must be at least 2");
   end

   // priority: bus write, then clear, then increment
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_o <= '0;
      else if (wr_i)    cnt_o <= wdata_i;
      else if (clr_i)   cnt_o <= '0;
      else if (inc_i)   cnt_o <= cnt_o + 1'b1;
   end

   assign wrap_o = inc_i && !wr_i && !clr_i && (&cnt_o);

   p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> cnt_o == $past(wdata_i));

   p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !wr_i) |=> cnt_o == '0);

   p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !clr_i && !wr_i) |=> cnt_o == $past(cnt_o));
endmodule

// File: rtl/evt_mon_ctrl.sv
`timescale 1ns/1ps
module evt_mon_ctrl
   import evt_mon_pkg::*;
#(
   parameter int SEL_W = 8
)(
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        wr_i,
   input  logic [DATA_W-1:0]           wdata_i,
   input  logic [NUM_CNT-1:0]          ovf_set_i,
   output logic                        en_o,
   output logic [NUM_CNT-2:0][SEL_W-1:0] sel_o,
   output logic                        ev_clr_o,
   output logic                        cy_clr_o,
   output logic [DATA_W-1:0]           word_o,
   output logic                        irq_o
);
   if (SEL1_LSB + SEL_W > SEL_TOP || SEL0_LSB + SEL_W > SEL1_LSB) begin : g_bad_sel
      $error("evt_mon_ctrl: selector width does not fit the control word");
   end

   logic                 en_q;
   logic [NUM_CNT-1:0]   ien_q;
   logic [NUM_CNT-1:0]   flag_q;
   logic [NUM_CNT-2:0][SEL_W-1:0] sel_q;
   logic [NUM_CNT-1:0]   w1c;
   logic                 irq_q;

   assign w1c = wr_i ? wdata_i[FLAG_LSB +: NUM_CNT] : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         ien_q  <= '0;
         sel_q  <= '0;
         flag_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_i) begin
            en_q     <= wdata_i[EN_BIT];
            ien_q    <= wdata_i[IEN_LSB +: NUM_CNT];
            sel_q[0] <= wdata_i[SEL0_LSB +: SEL_W];
            sel_q[1] <= wdata_i[SEL1_LSB +: SEL_W];
         end
         // a wrap on the same edge beats the write-one clear
         flag_q <= (flag_q & ~w1c) | ovf_set_i;
         irq_q  <= |(flag_q & ien_q);
      end
   end

   assign en_o     = en_q;
   assign sel_o    = sel_q;
   assign ev_clr_o = wr_i && wdata_i[EVCLR_BIT];
   assign cy_clr_o = wr_i && wdata_i[CYCLR_BIT];
   assign irq_o    = irq_q;

   always_comb begin
      word_o = '0;
      word_o[EN_BIT]               = en_q;
      word_o[IEN_LSB +: NUM_CNT]   = ien_q;
      word_o[FLAG_LSB +: NUM_CNT]  = flag_q;
      word_o[SEL0_LSB +: SEL_W]    = sel_q[0];
      word_o[SEL1_LSB +: SEL_W]    = sel_q[1];
   end

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_flag_chk
      p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ovf_set_i[k] |=> flag_q[k]);
      p_w1c_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (wr_i && wdata_i[FLAG_LSB + k] && !ovf_set_i[k]) |=> !flag_q[k]);
      p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (flag_q[k] && !(wr_i && wdata_i[FLAG_LSB + k])) |=> flag_q[k]);
   end

   p_irq_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(|(flag_q & ien_q)));
endmodule

// File: rtl/evt_mon_unit.sv
`timescale 1ns/1ps
module evt_mon_unit
   import evt_mon_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int SEL_W = 8,
   localparam int NUM_EVT = 1 << SEL_W
)(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               irq_o
);
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("evt_mon_unit: CNT_W must lie in 2..DATA_W");
   end

   logic                              en;
   logic [NUM_CNT-2:0][SEL_W-1:0]     sel;
   logic                              ev_clr;
   logic                              cy_clr;
   logic [DATA_W-1:0]                 ctrl_word;
   logic [NUM_CNT-1:0]                wrap;
   logic [NUM_CNT-1:0][CNT_W-1:0]     cnt;
   logic [NUM_CNT-1:0][DATA_W-1:0]    cnt_ext;

   evt_mon_ctrl #(.SEL_W(SEL_W)) i_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (bus_wr_i && bus_addr_i == ADDR_W'(0)),
      .wdata_i   (bus_wdata_i),
      .ovf_set_i (wrap),
      .en_o      (en),
      .sel_o     (sel),
      .ev_clr_o  (ev_clr),
      .cy_clr_o  (cy_clr),
      .word_o    (ctrl_word),
      .irq_o     (irq_o)
   );

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      logic inc;
      logic clr;
      logic wr;
      if (k == CNT_CY) begin : g_cyc
         assign inc = en;
         assign clr = cy_clr;
      end else begin : g_evt
         assign inc = en && (sel[k] != '1) && evt_i[sel[k]];
         assign clr = ev_clr;
      end
      assign wr = bus_wr_i && bus_addr_i == ADDR_W'(k + 1);

      evt_mon_ctr #(.W(CNT_W)) i_ctr (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .inc_i   (inc),
         .clr_i   (clr),
         .wr_i    (wr),
         .wdata_i (bus_wdata_i[CNT_W-1:0]),
         .cnt_o   (cnt[k]),
         .wrap_o  (wrap[k])
      );
      assign cnt_ext[k] = DATA_W'(cnt[k]);

      p_disabled_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!en && !bus_wr_i) |=> cnt[k] == $past(cnt[k]));

      if (k != CNT_CY) begin : g_unused_chk
         p_unused_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel[k] == '1 && !bus_wr_i) |=> cnt[k] == $past(cnt[k]));
      end
   end

   always_comb begin
      bus_rdata_o = ctrl_word;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (bus_addr_i == ADDR_W'(k + 1)) bus_rdata_o = cnt_ext[k];
      end
   end
endmodule

// File: tb/test_evt_mon_unit.sv
`timescale 1ns/1ps
module test_evt_mon_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr = 1'b0;
   logic [1:0]   addr = '0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic [255:0] evt = '0;
   logic         irq;
   int           n_chk = 0;
   int           n_err = 0;

   localparam logic [31:0] SEL_OFF = 32'h0FF0_0000 | 32'h000F_F000;

   evt_mon_unit i_evt_mon_unit (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive at a falling edge, lands on the next rising edge, return at the following falling edge
   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog (R1..all): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      for (int a = 0; a < 4; a++) begin
         bus_read(2'(a), v);
         check("R9 reset value", v, 32'h0);
      end
      check("R9 reset irq", {31'b0, irq}, 32'h0);

      // R9 counter write/read, R1 hold while disabled with all events high
      bus_write(2'd1, 32'h1234_5678);
      bus_write(2'd2, 32'h9ABC_DEF0);
      bus_write(2'd3, 32'h0BAD_F00D);
      evt = '1;
      repeat (5) @(negedge clk);
      evt = '0;
      bus_read(2'd1, v); check("R1 R9 event0 held", v, 32'h1234_5678);
      bus_read(2'd2, v); check("R1 R9 event1 held", v, 32'h9ABC_DEF0);
      bus_read(2'd3, v); check("R1 R9 cycle held", v, 32'h0BAD_F00D);

      // R2 clear strobes
      bus_write(2'd0, 32'h0000_0002);
      bus_read(2'd1, v); check("R2 event0 cleared", v, 32'h0);
      bus_read(2'd2, v); check("R2 event1 cleared", v, 32'h0);
      bus_read(2'd3, v); check("R2 cycle kept", v, 32'h0BAD_F00D);
      bus_read(2'd0, v); check("R2 strobe reads zero", v, 32'h0);
      bus_write(2'd0, 32'h0000_0004);
      bus_read(2'd3, v); check("R2 cycle cleared", v, 32'h0);

      // R7 reserved bits
      bus_write(2'd0, 32'hF000_0888);
      bus_read(2'd0, v); check("R7 reserved only", v, 32'h0);
      bus_write(2'd0, 32'hFFFF_FFFF);
      bus_read(2'd0, v); check("R7 all ones readback", v, 32'h0FFF_F071);
      bus_write(2'd0, SEL_OFF | 32'h6);

      // R1 cycle counting, R6 unused code with all events high
      evt = '1;
      bus_write(2'd0, SEL_OFF | 32'h1);
      repeat (9) @(negedge clk);
      bus_write(2'd0, SEL_OFF);
      evt = '0;
      bus_read(2'd3, v); check("R1 cycle count", v, 32'd10);
      bus_read(2'd1, v); check("R6 code 0xFF event0", v, 32'd0);
      bus_read(2'd2, v); check("R6 code 0xFF event1", v, 32'd0);

      // R6 two selectors with distinct patterns
      bus_write(2'd0, 32'h6);
      bus_write(2'd0, (32'h80 << 20) | (32'h05 << 12) | 32'h1);
      for (int i = 0; i < 12; i++) begin
         evt = '0;
         evt[6]    = 1'b1;
         evt[5]    = (i % 3 == 0);
         evt[8'h80] = (i % 2 == 1);
         @(negedge clk);
      end
      evt = '0;
      bus_write(2'd0, (32'h80 << 20) | (32'h05 << 12));
      bus_read(2'd1, v); check("R6 event0 pattern", v, 32'd4);
      bus_read(2'd2, v); check("R6 event1 pattern", v, 32'd6);
      bus_read(2'd3, v); check("R1 cycle during pattern", v, 32'd13);

      // R6 selector sweep
      for (int c = 0; c < 255; c += 3) begin
         int k1;
         k1 = c % 5 + 1;
         bus_write(2'd0, 32'h6);
         bus_write(2'd0, (32'(c ^ 1) << 20) | (32'(c) << 12) | 32'h1);
         for (int i = 0; i < k1; i++) begin
            evt = '0;
            evt[c] = 1'b1;
            @(negedge clk);
         end
         evt = '0;
         bus_write(2'd0, (32'(c ^ 1) << 20) | (32'(c) << 12));
         bus_read(2'd1, v); check($sformatf("R6 sweep code %0d event0", c), v, 32'(k1));
         bus_read(2'd2, v); check($sformatf("R6 sweep code %0d event1", c), v, 32'd0);
         bus_read(2'd3, v); check($sformatf("R1 sweep code %0d cycle", c), v, 32'(k1 + 1));
      end

      // R8 write beats increment
      bus_write(2'd0, SEL_OFF | 32'h6);
      bus_write(2'd0, SEL_OFF | 32'h1);
      repeat (3) @(negedge clk);
      bus_read(2'd3, v); check("R1 cycle before write", v, 32'd3);
      bus_write(2'd3, 32'h100);
      bus_read(2'd3, v); check("R8 write wins", v, 32'h100);
      @(negedge clk);
      bus_read(2'd3, v); check("R8 resumes after write", v, 32'h101);
      bus_write(2'd0, SEL_OFF);

      // R3 R5 event0 wrap with interrupt enable off
      bus_write(2'd1, 32'hFFFF_FFFF);
      bus_write(2'd0, (32'hFF << 20) | (32'h05 << 12) | 32'h1);
      evt[5] = 1'b1;
      @(negedge clk);
      evt = '0;
      bus_read(2'd1, v); check("R3 event0 wrapped", v, 32'h0);
      bus_read(2'd0, v); check("R3 event0 flag same edge", v & 32'h700, 32'h100);
      bus_write(2'd0, (32'hFF << 20) | (32'h05 << 12));
      @(negedge clk);
      check("R5 no irq when enable off", {31'b0, irq}, 32'h0);
      bus_write(2'd0, (32'hFF << 20) | (32'h05 << 12) | 32'h10);
      check("R5 irq one edge late", {31'b0, irq}, 32'h0);
      @(negedge clk);
      check("R5 irq raised", {31'b0, irq}, 32'h1);
      bus_write(2'd0, (32'hFF << 20) | (32'h05 << 12) | 32'h110);
      bus_read(2'd0, v); check("R4 write one clears", v & 32'h700, 32'h0);
      check("R5 irq still registered", {31'b0, irq}, 32'h1);
      @(negedge clk);
      check("R5 irq dropped", {31'b0, irq}, 32'h0);

      // R3 R5 cycle wrap with enable on
      bus_write(2'd0, SEL_OFF);
      bus_write(2'd3, 32'hFFFF_FFFD);
      bus_write(2'd0, SEL_OFF | 32'h41);
      check("R5 irq low start", {31'b0, irq}, 32'h0);
      @(negedge clk);
      @(negedge clk);
      bus_read(2'd0, v); check("R3 no flag before wrap", v & 32'h700, 32'h0);
      @(negedge clk);
      bus_read(2'd3, v); check("R3 cycle wrapped", v, 32'h0);
      bus_read(2'd0, v); check("R3 cycle flag same edge", v & 32'h700, 32'h400);
      check("R5 irq not yet", {31'b0, irq}, 32'h0);
      @(negedge clk);
      check("R5 irq after flag", {31'b0, irq}, 32'h1);
      bus_write(2'd0, SEL_OFF | 32'h440);
      bus_read(2'd0, v); check("R4 cycle flag cleared", v & 32'h700, 32'h0);
      @(negedge clk);
      check("R5 irq cleared", {31'b0, irq}, 32'h0);

      // R4 set wins over same-edge clear
      bus_write(2'd3, 32'hFFFF_FFFE);
      bus_write(2'd0, SEL_OFF | 32'h1);
      @(negedge clk);
      bus_write(2'd0, SEL_OFF | 32'h401);
      bus_write(2'd0, SEL_OFF);
      bus_read(2'd0, v); check("R4 set beats clear", v & 32'h700, 32'h400);
      bus_read(2'd3, v); check("R1 cycle after wrap", v, 32'h1);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule